// File: doc/BRIEF.md
# Single-Precision Divide Operand Fixup

This block sits in front of an iterative binary32 divider. It takes a numerator and a denominator and decides whether the quotient can be settled at once. NaN, infinity and zero operands are settled here. The block then hands final values forward with the needs-iteration bit low, along with invalid and divide-by-zero flag pulses.

For any other pair of operands, both values are rescaled by a power of two. The scale factor is picked from windows on the raw biased exponent fields. A later reciprocal-refinement loop then works on operands that can neither overflow nor underflow. An 8-bit adjust code tells the loop which of the two asymmetric rescalings was applied, so that it can undo the effect on the quotient.

The fixup logic itself is combinational. Its result is captured in one register stage, so a request presented with `in_valid` appears on the outputs one clock later.

Top module: `fdiv_operand_fixup`

## Requirements
- R1: A request accepted with `in_valid` high at a rising edge shows up with `out_valid` high after that edge. Without a request, `out_valid`, `out_iter`, `out_inv` and `out_dbz` are low after the edge. Reset clears all outputs to zero.
- R2: Any NaN operand produces 0xFFFFFFFF on `out_num`, `out_den` and `out_seed`. A NaN is an exponent field of all ones with a nonzero fraction, and it is signalling when fraction bit 22 is 0. A signalling NaN raises `out_inv`. With two NaNs, invalid is raised if either is signalling. NaN checks come before every other case.
- R3: Infinity over infinity and zero over zero, with either sign, produce 0xFFFFFFFF on all three value outputs and raise `out_inv`.
- R4: A zero denominator with a non-NaN numerator that is not zero gives `out_num` equal to infinity, with sign bit 31 equal to the XOR of the input signs. It also gives `out_den` = `out_seed` = 0x3F800000. `out_dbz` is raised only when the numerator is finite.
- R5: An infinite denominator, or a zero numerator, gives a zero with the XOR sign on `out_num`. This applies when none of the earlier cases hold, and the infinite-denominator check comes first. An infinite numerator over a finite nonzero denominator gives infinity with the XOR sign. In both cases `out_den` = `out_seed` = 0x3F800000.
- R6: Every settled case drives `out_adj` = 0x00 and `out_iter` = 0.
- R7: For finite nonzero operands with exponent fields N and D: if N-D+127 <= 23, `out_adj` = 0x80, the numerator is multiplied by 2^64 and the denominator by 2^-64.
- R8: Otherwise, if N-D+127 > 230, `out_adj` = 0x40, the numerator is multiplied by 2^-32 and the denominator by 2^32.
- R9: Otherwise `out_adj` = 0x00 and both operands are scaled by the same factor. The factor is 2^64 if N <= 25, else 2^32 if D <= 1, else 2^-32 if D > 252, else 1. In all non-settled cases `out_seed` = 0, `out_iter` = 1, and no flag is raised.
- R10: Scaling treats subnormal operands (exponent field 0) exactly, producing the normalised result. A result below the normal range is denormalised with round-to-nearest-even.
- R11: `out_inv` and `out_dbz` are never high together, and an invalid result always carries the NaN pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_num | input | 32 | Numerator, binary32 |
| in_den | input | 32 | Denominator, binary32 |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_num | output | 32 | Adjusted or final numerator |
| out_den | output | 32 | Adjusted or final denominator |
| out_seed | output | 32 | Initial quotient seed |
| out_adj | output | 8 | Adjust code (0x80, 0x40 or 0x00) |
| out_iter | output | 1 | High when the divider must iterate |
| out_inv | output | 1 | Invalid-operation pulse |
| out_dbz | output | 1 | Divide-by-zero pulse |

## Verification
The assertions assume that `in_valid` is low during reset. They also assume that each operand word may be any 32-bit pattern, so every bit combination at the inputs is legal, NaN payloads and subnormals included.

The stimulus changes inputs only on falling edges and holds `in_valid` low until reset is released. Operands are drawn from NaN, infinity, zero, subnormal and normal classes. Normal exponents are biased towards the window edges, so the settled cases, the asymmetric windows and each shared scaling branch are all reached.

// File: rtl/fdf_pkg.sv
package fdf_pkg;

  localparam int FP_W   = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int BIAS   = 127;
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  localparam logic [FP_W-1:0] QNAN_ALL = 32'hFFFF_FFFF;
  localparam logic [FP_W-1:0] FP_ONE   = 32'h3F80_0000;

  typedef struct packed {
    logic nan;
    logic quiet;
    logic inf;
    logic zero;
  } fp_class_t;

  // Highest set bit of a fraction field (0 when the field is empty).
  function automatic int lead_one(input logic [FRAC_W-1:0] f);
    int p;
    p = 0;
    for (int i = 0; i < FRAC_W; i++) begin
      if (f[i]) p = i;
    end
    return p;
  endfunction

  // Multiply a finite binary32 value by 2^k, normalising subnormal inputs
  // and denormalising with round-to-nearest-even when the result is tiny.
  function automatic logic [FP_W-1:0] scale_pow2(input logic [FP_W-1:0] x,
                                                 input int k);
    logic [SIG_W-1:0] sig;
    logic [2*SIG_W:0] ext;
    logic [SIG_W-1:0] kept;
    logic [SIG_W-1:0] rnd_sum;
    logic             rnd;
    logic             stk;
    int               be;
    int               nb;
    int               sh;
    int               p;
    if (x[FP_W-2 -: EXP_W] == '0) begin
      p   = lead_one(x[FRAC_W-1:0]);
      sig = {1'b0, x[FRAC_W-1:0]} << (FRAC_W - p);
      be  = p - (FRAC_W - 1);
    end else begin
      sig = {1'b1, x[FRAC_W-1:0]};
      be  = int'(x[FP_W-2 -: EXP_W]);
    end
    nb = be + k;
    if (nb >= EXP_MAX) begin
      return {x[FP_W-1], {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end
    if (nb >= 1) begin
      return {x[FP_W-1], nb[EXP_W-1:0], sig[FRAC_W-1:0]};
    end
    sh = 1 - nb;
    if (sh > SIG_W + 1) sh = SIG_W + 1;
    ext     = {sig, {(SIG_W+1){1'b0}}} >> sh;
    kept    = ext[2*SIG_W -: SIG_W];
    rnd     = ext[SIG_W];
    stk     = |ext[SIG_W-1:0];
    rnd_sum = kept + {{(SIG_W-1){1'b0}}, rnd & (stk | kept[0])};
    return {x[FP_W-1], {(FP_W-1-SIG_W){1'b0}}, rnd_sum};
  endfunction

endpackage

// File: rtl/fdf_classify.sv
module fdf_classify
  import fdf_pkg::*;
(
  input  logic [FP_W-1:0] x,
  output fp_class_t       c
);
  logic exp_ones;
  logic exp_zero;
  logic frac_zero;

  assign exp_ones  = &x[FP_W-2 -: EXP_W];
  assign exp_zero  = ~|x[FP_W-2 -: EXP_W];
  assign frac_zero = ~|x[FRAC_W-2:0] & ~x[FRAC_W-1];

  assign c.nan   = exp_ones & ~frac_zero;
  assign c.quiet = x[FRAC_W-1];
  assign c.inf   = exp_ones & frac_zero;
  assign c.zero  = exp_zero & frac_zero;
endmodule

// File: rtl/fdf_special.sv
module fdf_special
  import fdf_pkg::*;
(
  input  fp_class_t       nc,
  input  fp_class_t       dc,
  input  logic            n_sign,
  input  logic            d_sign,
  output logic            hit,
  output logic [FP_W-1:0] num,
  output logic [FP_W-1:0] den,
  output logic [FP_W-1:0] seed,
  output logic            inv,
  output logic            dbz
);
  localparam logic [FP_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic xs;
  assign xs = n_sign ^ d_sign;

  always_comb begin
    hit  = 1'b1;
    num  = QNAN_ALL;
    den  = QNAN_ALL;
    seed = QNAN_ALL;
    inv  = 1'b0;
    dbz  = 1'b0;
    if (nc.nan && dc.nan) begin
      inv = ~(nc.quiet & dc.quiet);
    end else if (nc.nan) begin
      inv = ~nc.quiet;
    end else if (dc.nan) begin
      inv = ~dc.quiet;
    end else if (nc.inf && dc.inf) begin
      inv = 1'b1;
    end else if (nc.zero && dc.zero) begin
      inv = 1'b1;
    end else if (dc.zero) begin
      num  = {xs, INF_MAG};
      den  = FP_ONE;
      seed = FP_ONE;
      dbz  = ~nc.inf;
    end else if (dc.inf || nc.zero) begin
      num  = {xs, {(FP_W-1){1'b0}}};
      den  = FP_ONE;
      seed = FP_ONE;
    end else if (nc.inf) begin
      num  = {xs, INF_MAG};
      den  = FP_ONE;
      seed = FP_ONE;
    end else begin
      hit  = 1'b0;
      seed = '0;
    end
  end
endmodule

// File: rtl/fdf_pow2_scale.sv
module fdf_pow2_scale
  import fdf_pkg::*;
#(
  parameter int SHIFT_W = 8
) (
  input  logic [FP_W-1:0]         x,
  input  logic signed [SHIFT_W-1:0] k,
  output logic [FP_W-1:0]         y
);
  assign y = scale_pow2(x, int'(k));
endmodule

// File: rtl/fdf_prescale.sv
module fdf_prescale
  import fdf_pkg::*;
#(
  parameter int          LO_LIMIT     = 23,
  parameter int          HI_LIMIT     = 230,
  parameter int          NUM_SMALL    = 25,
  parameter int          DEN_TINY     = 1,
  parameter int          DEN_HUGE     = 252,
  parameter int          WIDE_SHIFT   = 64,
  parameter int          NARROW_SHIFT = 32,
  parameter logic [7:0]  ADJ_LO       = 8'h80,
  parameter logic [7:0]  ADJ_HI       = 8'h40
) (
  input  logic [FP_W-1:0] n,
  input  logic [FP_W-1:0] d,
  output logic [FP_W-1:0] n_out,
  output logic [FP_W-1:0] d_out,
  output logic [7:0]      adj,
  output logic            win_lo,
  output logic            win_hi
);
  localparam int SHIFT_W = $clog2(WIDE_SHIFT) + 2;
  localparam int NOPS    = 2;

  typedef logic signed [SHIFT_W-1:0] shift_t;

  localparam shift_t UP_W = shift_t'(WIDE_SHIFT);
  localparam shift_t DN_W = shift_t'(-WIDE_SHIFT);
  localparam shift_t UP_N = shift_t'(NARROW_SHIFT);
  localparam shift_t DN_N = shift_t'(-NARROW_SHIFT);

  int     n_exp;
  int     d_exp;
  int     gap;
  shift_t kv [NOPS];
  logic [FP_W-1:0] xin  [NOPS];
  logic [FP_W-1:0] xout [NOPS];

  assign n_exp = int'(n[FP_W-2 -: EXP_W]);
  assign d_exp = int'(d[FP_W-2 -: EXP_W]);
  assign gap   = n_exp - d_exp + BIAS;

  always_comb begin
    win_lo = 1'b0;
    win_hi = 1'b0;
    adj    = 8'h00;
    kv[0]  = '0;
    kv[1]  = '0;
    if (gap <= LO_LIMIT) begin
      win_lo = 1'b1;
      adj    = ADJ_LO;
      kv[0]  = UP_W;
      kv[1]  = DN_W;
    end else if (gap > HI_LIMIT) begin
      win_hi = 1'b1;
      adj    = ADJ_HI;
      kv[0]  = DN_N;
      kv[1]  = UP_N;
    end else if (n_exp <= NUM_SMALL) begin
      kv[0] = UP_W;
      kv[1] = UP_W;
    end else if (d_exp <= DEN_TINY) begin
      kv[0] = UP_N;
      kv[1] = UP_N;
    end else if (d_exp > DEN_HUGE) begin
      kv[0] = DN_N;
      kv[1] = DN_N;
    end
  end

  assign xin[0] = n;
  assign xin[1] = d;

  for (genvar g = 0; g < NOPS; g++) begin : g_scale
    fdf_pow2_scale #(.SHIFT_W(SHIFT_W)) u_scale (
      .x(xin[g]),
      .k(kv[g]),
      .y(xout[g])
    );
  end

  assign n_out = xout[0];
  assign d_out = xout[1];
endmodule

// File: rtl/fdiv_operand_fixup.sv
module fdiv_operand_fixup
  import fdf_pkg::*;
#(
  parameter int          LO_LIMIT     = 23,
  parameter int          HI_LIMIT     = 230,
  parameter int          NUM_SMALL    = 25,
  parameter int          DEN_TINY     = 1,
  parameter int          DEN_HUGE     = 252,
  parameter int          WIDE_SHIFT   = 64,
  parameter int          NARROW_SHIFT = 32,
  parameter logic [7:0]  ADJ_LO       = 8'h80,
  parameter logic [7:0]  ADJ_HI       = 8'h40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_num,
  input  logic [31:0] in_den,
  output logic        out_valid,
  output logic [31:0] out_num,
  output logic [31:0] out_den,
  output logic [31:0] out_seed,
  output logic [7:0]  out_adj,
  output logic        out_iter,
  output logic        out_inv,
  output logic        out_dbz
);
  localparam int NOPS = 2;

  logic [FP_W-1:0] opnd [NOPS];
  fp_class_t       cls  [NOPS];

  assign opnd[0] = in_num;
  assign opnd[1] = in_den;

  for (genvar g = 0; g < NOPS; g++) begin : g_cls
    fdf_classify u_cls (.x(opnd[g]), .c(cls[g]));
  end

  // Named internal events, observed by the bound checker.
  logic            fix_special_c;
  logic            win_lo_c;
  logic            win_hi_c;

  logic [FP_W-1:0] sp_num, sp_den, sp_seed;
  logic            sp_inv, sp_dbz;
  logic [FP_W-1:0] ps_num, ps_den;
  logic [7:0]      ps_adj;

  fdf_special u_special (
    .nc     (cls[0]),
    .dc     (cls[1]),
    .n_sign (in_num[FP_W-1]),
    .d_sign (in_den[FP_W-1]),
    .hit    (fix_special_c),
    .num    (sp_num),
    .den    (sp_den),
    .seed   (sp_seed),
    .inv    (sp_inv),
    .dbz    (sp_dbz)
  );

  fdf_prescale #(
    .LO_LIMIT     (LO_LIMIT),
    .HI_LIMIT     (HI_LIMIT),
    .NUM_SMALL    (NUM_SMALL),
    .DEN_TINY     (DEN_TINY),
    .DEN_HUGE     (DEN_HUGE),
    .WIDE_SHIFT   (WIDE_SHIFT),
    .NARROW_SHIFT (NARROW_SHIFT),
    .ADJ_LO       (ADJ_LO),
    .ADJ_HI       (ADJ_HI)
  ) u_prescale (
    .n      (in_num),
    .d      (in_den),
    .n_out  (ps_num),
    .d_out  (ps_den),
    .adj    (ps_adj),
    .win_lo (win_lo_c),
    .win_hi (win_hi_c)
  );

  logic [FP_W-1:0] nx_num, nx_den;
  logic [7:0]      nx_adj;

  assign nx_num = fix_special_c ? sp_num : ps_num;
  assign nx_den = fix_special_c ? sp_den : ps_den;
  assign nx_adj = fix_special_c ? 8'h00  : ps_adj;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_num   <= '0;
      out_den   <= '0;
      out_seed  <= '0;
      out_adj   <= '0;
      out_iter  <= 1'b0;
      out_inv   <= 1'b0;
      out_dbz   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_iter  <= in_valid & ~fix_special_c;
      out_inv   <= in_valid & sp_inv;
      out_dbz   <= in_valid & sp_dbz;
      if (in_valid) begin
        out_num  <= nx_num;
        out_den  <= nx_den;
        out_seed <= sp_seed;
        out_adj  <= nx_adj;
      end
    end
  end
endmodule

// File: rtl/fdiv_operand_fixup_chk.sv
module fdiv_operand_fixup_chk
  import fdf_pkg::*;
#(
  parameter logic [7:0] ADJ_LO = 8'h80,
  parameter logic [7:0] ADJ_HI = 8'h40
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        fix_special_c,
  input logic        win_lo_c,
  input logic        win_hi_c,
  input logic        out_valid,
  input logic [31:0] out_num,
  input logic [31:0] out_den,
  input logic [31:0] out_seed,
  input logic [7:0]  out_adj,
  input logic        out_iter,
  input logic        out_inv,
  input logic        out_dbz
);
  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_iter && !out_inv && !out_dbz));

  p_nan_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_num == QNAN_ALL) |->
      (out_den == QNAN_ALL && out_seed == QNAN_ALL && !out_iter));

  p_inv_nan_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_inv |-> out_num == QNAN_ALL);

  p_dbz_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_dbz |-> (out_num[30:0] == 31'h7F80_0000 && out_den == FP_ONE &&
                 out_seed == FP_ONE));

  p_special_adj_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_iter) |-> out_adj == 8'h00);

  p_special_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fix_special_c) |=> !out_iter);

  p_lo_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fix_special_c && win_lo_c) |=> (out_adj == ADJ_LO && out_iter));

  p_hi_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fix_special_c && win_hi_c) |=> (out_adj == ADJ_HI && out_iter));

  p_iter_seed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_iter |-> (out_seed == 32'h0 && !out_inv && !out_dbz));

  p_flag_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({out_inv, out_dbz}) <= 1);
endmodule

bind fdiv_operand_fixup fdiv_operand_fixup_chk #(
  .ADJ_LO (ADJ_LO),
  .ADJ_HI (ADJ_HI)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .fix_special_c (fix_special_c),
  .win_lo_c      (win_lo_c),
  .win_hi_c      (win_hi_c),
  .out_valid     (out_valid),
  .out_num       (out_num),
  .out_den       (out_den),
  .out_seed      (out_seed),
  .out_adj       (out_adj),
  .out_iter      (out_iter),
  .out_inv       (out_inv),
  .out_dbz       (out_dbz)
);

// File: tb/fdiv_operand_fixup_test.sv
`timescale 1ns/1ps
module fdiv_operand_fixup_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_num = '0;
  logic [31:0] in_den = '0;
  logic        out_valid;
  logic [31:0] out_num, out_den, out_seed;
  logic [7:0]  out_adj;
  logic        out_iter, out_inv, out_dbz;

  always #4 clk = ~clk;

  fdiv_operand_fixup uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_num(in_num), .in_den(in_den),
    .out_valid(out_valid), .out_num(out_num), .out_den(out_den),
    .out_seed(out_seed), .out_adj(out_adj), .out_iter(out_iter),
    .out_inv(out_inv), .out_dbz(out_dbz)
  );

  typedef struct packed {
    logic [31:0] num;
    logic [31:0] den;
    logic [31:0] seed;
    logic [7:0]  adj;
    logic        iter;
    logic        inv;
    logic        dbz;
  } exp_t;

  exp_t  expq [$];
  string tagq [$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;

  localparam logic [31:0] NANW = 32'hFFFF_FFFF;
  localparam logic [31:0] ONEW = 32'h3F80_0000;

  function automatic bit b_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic bit b_inf(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] == 0);
  endfunction
  function automatic bit b_zero(input logic [31:0] x);
    return x[30:0] == 0;
  endfunction

  // Value = m * 2^q; rebuild the encoding of m * 2^(q+k).
  function automatic logic [31:0] m_scale(input logic [31:0] x, input int k);
    longint m, r, rem, half;
    int q, lead, e, sh;
    if (x[30:23] == 0) begin
      m = longint'(x[22:0]);
      q = -149;
    end else begin
      m = longint'({1'b1, x[22:0]});
      q = int'(x[30:23]) - 150;
    end
    q = q + k;
    lead = 0;
    for (int i = 0; i < 24; i++) if (m[i]) lead = i;
    e = q + 150 + lead - 23;
    if (e >= 255) return {x[31], 8'hFF, 23'd0};
    if (e >= 1) begin
      m = m << (23 - lead);
      return {x[31], e[7:0], m[22:0]};
    end
    sh = -(q + 149);
    if (sh <= 0) r = m << (-sh);
    else if (sh > 40) r = 0;
    else begin
      r    = m >> sh;
      rem  = m & ((64'sd1 << sh) - 1);
      half = 64'sd1 << (sh - 1);
      if (rem > half || (rem == half && r[0])) r = r + 1;
    end
    return {x[31], r[30:0]};
  endfunction

  function automatic exp_t model(input logic [31:0] n, input logic [31:0] d,
                                 output string tag);
    exp_t e;
    logic s;
    int ne, de, gap, kn, kd;
    s = n[31] ^ d[31];
    e = '{num: NANW, den: NANW, seed: NANW, adj: 8'h00, iter: 1'b0,
          inv: 1'b0, dbz: 1'b0};
    if (b_nan(n) || b_nan(d)) begin
      tag = "R2";
      e.inv = (b_nan(n) && !n[22]) || (b_nan(d) && !d[22]);
    end else if ((b_inf(n) && b_inf(d)) || (b_zero(n) && b_zero(d))) begin
      tag = "R3";
      e.inv = 1'b1;
    end else if (b_zero(d)) begin
      tag = "R4";
      e.num = {s, 8'hFF, 23'd0}; e.den = ONEW; e.seed = ONEW;
      e.dbz = !b_inf(n);
    end else if (b_inf(d) || b_zero(n)) begin
      tag = "R5";
      e.num = {s, 31'd0}; e.den = ONEW; e.seed = ONEW;
    end else if (b_inf(n)) begin
      tag = "R5";
      e.num = {s, 8'hFF, 23'd0}; e.den = ONEW; e.seed = ONEW;
    end else begin
      ne = int'(n[30:23]);
      de = int'(d[30:23]);
      gap = ne - de + 127;
      kn = 0; kd = 0;
      tag = (ne == 0 || de == 0) ? "R10" : "R9";
      if (gap <= 23)       begin kn = 64;  kd = -64; e.adj = 8'h80; tag = "R7"; end
      else if (gap > 230)  begin kn = -32; kd = 32;  e.adj = 8'h40; tag = "R8"; end
      else if (ne <= 25)   begin kn = 64;  kd = 64;  end
      else if (de <= 1)    begin kn = 32;  kd = 32;  end
      else if (de > 252)   begin kn = -32; kd = -32; end
      e.num  = m_scale(n, kn);
      e.den  = m_scale(d, kd);
      e.seed = 32'h0;
      e.iter = 1'b1;
    end
    return e;
  endfunction

  task automatic send(input logic [31:0] n, input logic [31:0] d);
    string t;
    exp_t  e;
    e = model(n, d, t);
    @(negedge clk);
    in_num   = n;
    in_den   = d;
    in_valid = 1'b1;
    expq.push_back(e);
    tagq.push_back(t);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] gen_op();
    logic s;
    logic [22:0] f;
    int t, ex;
    s = 1'($urandom);
    f = 23'($urandom);
    t = $urandom % 10;
    case (t)
      0: return {s, 8'hFF, 1'b1, f[21:0]};
      1: return {s, 8'hFF, 1'b0, f[21:1], 1'b1};
      2: return {s, 8'hFF, 23'd0};
      3: return {s, 31'd0};
      4: return {s, 8'h00, f[22:1], 1'b1};
      default: begin
        case ($urandom % 4)
          0: ex = 1 + int'($urandom % 30);
          1: ex = 225 + int'($urandom % 30);
          2: ex = 90 + int'($urandom % 70);
          default: ex = 1 + int'($urandom % 254);
        endcase
        return {s, ex[7:0], f};
      end
    endcase
  endfunction

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (out_valid) begin
          exp_t  e;
          exp_t  a;
          string t;
          a = '{num: out_num, den: out_den, seed: out_seed, adj: out_adj,
                iter: out_iter, inv: out_inv, dbz: out_dbz};
          n_chk++;
          if (expq.size() == 0) begin
            n_bad++;
            $display("FAIL R1 unexpected result actual=%h expected=none", a);
          end else begin
            e = expq.pop_front();
            t = tagq.pop_front();
            if (a !== e) begin
              n_bad++;
              $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
            if (!e.iter) begin
              n_chk++;
              if (out_adj !== 8'h00 || out_iter !== 1'b0) begin
                n_bad++;
                $display("FAIL R6 adj/iter actual=%h/%b expected=00/0",
                         out_adj, out_iter);
              end
            end
          end
          n_chk++;
          if (out_inv && out_dbz) begin
            n_bad++;
            $display("FAIL R11 inv/dbz actual=1/1 expected=exclusive");
          end
        end else begin
          n_chk++;
          if (out_iter || out_inv || out_dbz) begin
            n_bad++;
            $display("FAIL R1 idle flags actual=%b%b%b expected=000",
                     out_iter, out_inv, out_dbz);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state, R1
    n_chk++;
    if (out_valid !== 1'b0 || out_num !== 32'h0 || out_adj !== 8'h0 ||
        out_iter !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset actual=%b/%h/%h expected=0/0/0",
               out_valid, out_num, out_adj);
    end
    rst_n = 1'b1;
    idle();

    // R2: NaN cases, priority over everything
    send(32'h7FC0_0001, 32'hFFC0_0000);   // both quiet: no invalid
    send(32'h7F80_0001, 32'h7FC0_0000);   // signalling numerator
    send(32'h7FC0_0000, 32'h7FA0_0000);   // signalling denominator
    send(32'hFFC1_2345, 32'h0000_0000);   // NaN over zero: no dbz
    send(32'h3F80_0000, 32'h7F90_0000);   // sNaN denominator alone
    // R3
    send(32'h7F80_0000, 32'hFF80_0000);
    send(32'h8000_0000, 32'h0000_0000);
    // R4
    send(32'h40A0_0000, 32'h8000_0000);   // dbz, negative infinity
    send(32'hFF80_0000, 32'h0000_0000);   // infinite numerator: no dbz
    send(32'h0000_0003, 32'h0000_0000);   // subnormal over zero
    // R5
    send(32'h4040_0000, 32'hFF80_0000);
    send(32'h8000_0000, 32'h40E0_0000);
    send(32'h0000_0000, 32'h7F80_0000);
    send(32'hFF80_0000, 32'h4000_0000);
    // R7 / R8 / R9 / R10 windows and edges
    send(32'h0000_0001, 32'h3F80_0000);   // R7 R10 expect 15000000/1F800000
    send(32'h0B80_0000, 32'h3F80_0000);   // R7 gap exactly 23
    send(32'h0C00_0000, 32'h3F80_0000);   // R9 gap 24, N<=25
    send(32'h7F00_0000, 32'h3F80_0000);   // R8 expect 6F000000/4F800000
    send(32'h7300_0000, 32'h3F80_0000);   // gap 230: no scaling R9
    send(32'h7380_0000, 32'h3F80_0000);   // gap 231: R8
    send(32'h0C80_0000, 32'h0C00_0000);   // R9 N=25
    send(32'h3200_0000, 32'h0080_0000);   // R9 D=1
    send(32'h2D00_0000, 32'h0040_0000);   // R10 D=0 subnormal
    send(32'h4B00_0000, 32'h7E80_0000);   // R9 D=253
    send(32'h4040_0000, 32'hC000_0000);   // R9 unchanged
    send(32'hBFC0_1234, 32'h4123_4567);
    idle();
    idle();

    for (int i = 0; i < 3000; i++) begin
      send(gen_op(), gen_op());
      if ($urandom % 5 == 0) idle();
    end
    idle();
    repeat (5) @(negedge clk);
    n_chk++;
    if (expq.size() != 0) begin
      n_bad++;
      $display("FAIL R1 pending actual=%0d expected=0", expq.size());
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule